// File: doc/BRIEF.md
# Multi-Channel Contact Settling Filter

This block cleans up a vector of independent mechanical contacts such as pushbuttons and switches, all on one system clock. Each raw input is first brought into the clock domain through two flip-flops in series. Each channel then has its own stability counter. The counter restarts whenever the two synchronizer stages disagree. The cleaned output of a channel copies the synchronized value only after that value has held long enough for the counter's top bit to set.

The settling time is given in physical units: the clock period in nanoseconds and the wanted settle time in milliseconds. The block divides one by the other to get a tick count. It rounds that count up to a power of two, K, and sizes each counter at log2(K)+1 bits. Because every channel counts on its own, a contact that keeps bouncing never holds back the others. For simulation, the timing parameters can be overridden so that K is only a few clocks.

Top module: `btn_settle`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `clean_o` becomes 0 and every channel's counter is cleared.
- R2: Each `raw_i` bit passes through two flip-flops in series before any other logic uses it.
- R3: A channel's counter is cleared on every clock edge where its two synchronizer stages hold different values.
- R4: A channel's output does not change while its counter's top bit is 0. As a result, an input pulse held for fewer than K+2 sampling edges never reaches `clean_o`.
- R5: Once the top bit is set, the counter holds its value for as long as the input stays stable. It does not wrap, and the output keeps following the stable input indefinitely.
- R6: After a step on `raw_i` that is first sampled at edge e1 and then held, `clean_o` shows the new value right after edge e(K+3) and not before. A pulse held for L ≥ K+2 sampling edges appears on `clean_o` for exactly L cycles.
- R7: Channels are independent. Continuous bouncing on one input neither delays nor alters the settled output of another.
- R8: K = 2^ceil(log2(SETTLE_MS·10^6 / CLK_PERIOD_NS)), with a minimum of 1. The counter is log2(K)+1 bits wide, and its top bit marks "settled".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| raw_i | input | NUM_CH | Unsynchronized contact levels, one bit per channel |
| clean_o | output | NUM_CH | Registered, settled contact levels |

## Verification
Every cycle, the assertions check the local mechanics of each channel:
- each synchronizer stage equals the previous cycle's value of the stage before it;
- the counter clears after any disagreement between the stages;
- the output is frozen while the counter's top bit is clear;
- a settled counter stays settled while the input is stable, and the output then copies the second stage.

Only the bench's scenarios can show the end-to-end figures: the exact K+3 edge latency, the K+2 edge boundary between rejected and accepted pulses, the L-cycle width of an accepted pulse, and that bouncing on one channel leaves another channel's timing untouched. The bench sweeps pulse length across that boundary on every channel.

// File: rtl/btn_settle_pkg.sv
package btn_settle_pkg;

  // Number of counter bits below the "settled" flag: ceil(log2(ticks)),
  // where ticks = settle time / clock period, at least one tick.
  function automatic int settle_bits(input longint period_ns, input longint settle_ms);
    longint ticks;
    int     b;
    ticks = (settle_ms * 64'd1000000) / period_ns;
    if (ticks < 1) ticks = 1;
    b = 0;
    while ((64'd1 << b) < ticks) b++;
    return b;
  endfunction

endpackage

// File: rtl/btn_settle_sync.sv
module btn_settle_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] stage1_o,
  output logic [WIDTH-1:0] stage2_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_o <= '0;
      stage2_o <= '0;
    end else begin
      stage1_o <= raw_i;
      stage2_o <= stage1_o;
    end
  end

  // R2: first stage samples the pins, second stage samples the first
  a_r2_first_stage: assert property (@(posedge clk) disable iff (rst)
    stage1_o == $past(raw_i));
  a_r2_second_stage: assert property (@(posedge clk) disable iff (rst)
    stage2_o == $past(stage1_o));

endmodule

// File: rtl/btn_settle_chan.sv
module btn_settle_chan #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stage1_i,
  input  logic stage2_i,
  output logic clean_o
);

  logic [CNT_W:0] cnt;
  logic           settled;
  logic           moving;

  assign settled = cnt[CNT_W];
  assign moving  = stage1_i ^ stage2_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      clean_o <= 1'b0;
    end else if (moving) begin
      cnt <= '0;
    end else if (!settled) begin
      cnt <= cnt + 1'b1;
    end else begin
      clean_o <= stage2_i;
    end
  end

  // R3: a disagreement between stages restarts the count
  a_r3_clear_on_change: assert property (@(posedge clk) disable iff (rst)
    moving |=> (cnt == '0));
  // R4: output frozen until the top bit is set
  a_r4_hold_until_settled: assert property (@(posedge clk) disable iff (rst)
    !settled |=> $stable(clean_o));
  // R5: a settled counter on a stable input stays settled (no wrap)
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (settled && !moving) |=> settled);
  // R6: once settled and stable, the output copies the second stage
  a_r6_follow_stable: assert property (@(posedge clk) disable iff (rst)
    (settled && !moving) |=> (clean_o == $past(stage2_i)));

endmodule

// File: rtl/btn_settle.sv
module btn_settle
  import btn_settle_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SETTLE_MS     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] raw_i,
  output logic [NUM_CH-1:0] clean_o
);

  // R8: counter width derived from physical timing
  localparam int CNT_W = settle_bits(CLK_PERIOD_NS, SETTLE_MS);

  logic [NUM_CH-1:0] stage1;
  logic [NUM_CH-1:0] stage2;

  btn_settle_sync #(.WIDTH(NUM_CH)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .raw_i    (raw_i),
    .stage1_o (stage1),
    .stage2_o (stage2)
  );

  // R7: one private counter per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    btn_settle_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .stage1_i (stage1[ch]),
      .stage2_i (stage2[ch]),
      .clean_o  (clean_o[ch])
    );
  end

endmodule

// File: tb/sim_btn_settle.sv
module sim_btn_settle;

  localparam int CLK_NS = 10;
  localparam int NCH    = 4;
  localparam int PER_NS = 1000000;
  localparam int SET_MS = 4;

  function automatic int ref_k(input longint per, input longint ms);
    longint ticks;
    int     k;
    ticks = (ms * 64'd1000000) / per;
    k = 1;
    while (k < ticks) k = k * 2;
    return k;
  endfunction

  localparam int K = ref_k(PER_NS, SET_MS);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] raw = '0;
  logic [NCH-1:0] clean;
  int             checks = 0;
  int             failures = 0;

  btn_settle #(.NUM_CH(NCH), .CLK_PERIOD_NS(PER_NS), .SETTLE_MS(SET_MS)) u0 (
    .clk(clk), .rst(rst), .raw_i(raw), .clean_o(clean)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NCH-1:0] mask;
    int             seen;
    @(negedge clk);
    tick(3);
    check("R1 reset clears outputs", clean, '0);
    rst = 1'b0;
    tick(K * 4);
    check("R1 R5 idle low stays low", clean, '0);

    // R6 R8 step latency on each channel, then R5 long hold
    for (int c = 0; c < NCH; c++) begin
      mask = '0;
      mask[c] = 1'b1;
      raw = raw | mask;
      tick(K + 2);
      check("R6 R8 before edge K+3", clean, raw & ~mask);
      tick(1);
      check("R6 R2 after edge K+3", clean, raw);
      tick(K * 5);
      check("R5 stable after long hold", clean, raw);
    end
    raw = '0;
    tick(K + 3);
    check("R6 step down latency", clean, '0);

    // R4 R6 pulse-length sweep across the K+2 boundary on every channel
    for (int c = 0; c < NCH; c++) begin
      for (int len = 1; len <= K + 4; len++) begin
        seen = 0;
        raw = '0;
        raw[c] = 1'b1;
        for (int i = 0; i < len; i++) begin
          tick(1);
          if (clean[c]) seen++;
        end
        raw[c] = 1'b0;
        for (int i = 0; i < K + 8; i++) begin
          tick(1);
          if (clean[c]) seen++;
        end
        if (len >= K + 2)
          check("R6 accepted pulse width", NCH'(seen), NCH'(len));
        else
          check("R4 short pulse rejected", NCH'(seen), '0);
        check("R7 other channels quiet", clean, '0);
      end
    end

    // R7 bouncing channel 0 against a clean step on channel 1
    raw = '0;
    for (int i = 1; i <= K + 3; i++) begin
      raw[0] = 1'((i >> 1) & 1);
      raw[1] = 1'b1;
      tick(1);
      if (i == K + 2) check("R7 ch1 not yet", {clean[3:1], 1'b0}, '0);
      if (i == K + 3) check("R7 ch1 on time", {clean[3:1], 1'b0}, 4'b0010);
      check("R7 R3 bouncing ch0 stays low", {3'b0, clean[0]}, '0);
    end
    raw = '0;
    tick(K + 3);
    check("R7 all low again", clean, '0);

    rst = 1'b1;
    tick(1);
    check("R1 reset mid run", clean, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule